// File: doc/BRIEF.md
# Serial Offset Register Chain

This block stores the almost-empty and almost-full threshold offsets for a group of FIFO channels and drives them in parallel to each channel's flag logic. Software-side logic programs the offsets through a single serial input, one bit per clock, and can read them back one bit per clock through a serial output. Every register takes part in a single logical chain of fixed order. A load strobe writes the next chain bit. A read strobe presents the next chain bit. Neither strobe disturbs bits it does not address.

The chain has two configurations, and the block samples the choice during master reset. In the full configuration every channel takes part: each channel has one almost-empty and one almost-full register, and the chain starts at the highest channel. In the half configuration only the lower half of the channels takes part. The chain is then half as long, and the upper registers are neither written nor read, so they keep their reset defaults. Load and read positions are tracked separately. Each wraps to the start of the chain after its last bit. A load that stops partway therefore resumes where it stopped.

Top module: `ofs_chain`

## Requirements
- R1: While master reset `mrs` is high at a clock edge, every almost-empty register loads `AE_DEFAULT`, every almost-full register loads `AF_DEFAULT`, `serialOut` clears to 0, and both chain positions return to bit 0.
- R2: In the full configuration the chain is 2*NUM_CH registers long, in this order: almost-empty of channel NUM_CH-1, almost-full of channel NUM_CH-1, almost-empty of channel NUM_CH-2, and so on down to almost-full of channel 0.
- R3: Each register occupies OFS_W consecutive chain bits, least significant bit first. Channel c's offsets appear at bits [c*OFS_W +: OFS_W] of `aeOffsets` and `afOffsets`.
- R4: In the half configuration (`quadSel` low during reset) the chain holds only channels NUM_CH/2-1 down to 0, in the same interleaved order. The registers of the upper channels keep their defaults and are never presented on `serialOut`.
- R5: A read strobe registers the chain bit at the read position onto `serialOut`, one clock after the strobe, and advances the read position. Reading never changes any stored offset.
- R6: After the last bit of the active chain, the read position wraps, so the next read returns the first chain bit again. The load position wraps in the same way.
- R7: Each load strobe writes `serialIn` into exactly one chain bit. A load stopped after k bits leaves every later bit unchanged, and the next load continues at bit k.
- R8: When load and read strobes are high together, only the load takes effect: `serialOut` holds and the read position does not advance.
- R9: A change on `quadSel` outside reset has no effect. The configuration sampled at the last reset stays in force.
- R10: With no read strobe, `serialOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| mrs | input | 1 | Synchronous master reset, active high |
| quadSel | input | 1 | Configuration select sampled during reset: 1 full, 0 half |
| serialIn | input | 1 | Serial data bit written by a load strobe |
| loadEn | input | 1 | Load strobe |
| readEn | input | 1 | Read strobe |
| serialOut | output | 1 | Registered read-back bit |
| aeOffsets | output | NUM_CH*OFS_W | Almost-empty offsets, channel c at [c*OFS_W +: OFS_W] |
| afOffsets | output | NUM_CH*OFS_W | Almost-full offsets, channel c at [c*OFS_W +: OFS_W] |

## Verification
A wrong load position or a wrong slot-to-channel mapping shows up on the parallel offset outputs in the cycle after the bad load strobe. Loading words with distinct values into every slot exposes such a fault at the end of one chain pass. A wrong read position, wrap point or chain length in either configuration shows up on `serialOut` one clock after the read strobe, so the bench compares every streamed bit against a model and reads one register beyond the wrap. A read path that corrupts storage, or a configuration that leaks in after reset, shows up as parallel outputs that change when they should hold.

// File: rtl/ofs_chain_pkg.sv
package ofs_chain_pkg;

  // Strobes passed from the chain control to the offset storage.
  typedef struct packed {
    logic wr;    // write serialIn into the addressed bit
    logic rd;    // present the addressed bit on serialOut
    logic wrAf;  // write target is the almost-full register
    logic rdAf;  // read source is the almost-full register
  } ofsStrobe_t;

endpackage

// File: rtl/ofs_chain_ctrl.sv
module ofs_chain_ctrl
  import ofs_chain_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int OFS_W  = 16
) (
  input  logic                     clk,
  input  logic                     mrs,
  input  logic                     quadSel,
  input  logic                     loadEn,
  input  logic                     readEn,
  output ofsStrobe_t               strb,
  output logic [$clog2(NUM_CH)-1:0] wrCh,
  output logic [$clog2(NUM_CH)-1:0] rdCh,
  output logic [$clog2(OFS_W)-1:0]  wrBit,
  output logic [$clog2(OFS_W)-1:0]  rdBit,
  output logic                     quadMode
);

  localparam int SLOTS = 2 * NUM_CH;
  localparam int SW    = $clog2(SLOTS);
  localparam int CHW   = $clog2(NUM_CH);
  localparam int BW    = $clog2(OFS_W);
  localparam logic [BW-1:0] LAST_BIT  = BW'(OFS_W - 1);
  localparam logic [SW-1:0] LAST_FULL = SW'(SLOTS - 1);
  localparam logic [SW-1:0] LAST_HALF = SW'(NUM_CH - 1);

  logic          cfgQuad;
  logic [SW-1:0] wrSlot, rdSlot;
  logic [SW-1:0] lastSlot;
  logic          wrGo, rdGo;

  assign lastSlot = cfgQuad ? LAST_FULL : LAST_HALF;
  assign wrGo     = loadEn;
  assign rdGo     = readEn & ~loadEn;   // load wins on a collision

  function automatic logic [CHW-1:0] slotToCh(input logic [SW-1:0] s, input logic q);
    int active;
    active = q ? NUM_CH : NUM_CH / 2;
    return CHW'(active - 1 - int'(s >> 1));
  endfunction

  always_ff @(posedge clk) begin
    if (mrs) begin
      cfgQuad <= quadSel;
      wrSlot  <= '0;
      wrBit   <= '0;
      rdSlot  <= '0;
      rdBit   <= '0;
    end else begin
      if (wrGo) begin
        if (wrBit == LAST_BIT) begin
          wrBit  <= '0;
          wrSlot <= (wrSlot == lastSlot) ? '0 : wrSlot + 1'b1;
        end else begin
          wrBit <= wrBit + 1'b1;
        end
      end
      if (rdGo) begin
        if (rdBit == LAST_BIT) begin
          rdBit  <= '0;
          rdSlot <= (rdSlot == lastSlot) ? '0 : rdSlot + 1'b1;
        end else begin
          rdBit <= rdBit + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.wr   = wrGo;
    strb.rd   = rdGo;
    strb.wrAf = wrSlot[0];
    strb.rdAf = rdSlot[0];
    wrCh      = slotToCh(wrSlot, cfgQuad);
    rdCh      = slotToCh(rdSlot, cfgQuad);
    quadMode  = cfgQuad;
  end

  // R9: configuration only moves under reset
  p_cfg_stable_r9: assert property (@(posedge clk) disable iff (mrs)
    !mrs |=> $stable(cfgQuad));

  // R4/R6: neither position ever leaves the active chain
  p_slot_range_r4: assert property (@(posedge clk) disable iff (mrs)
    (wrSlot <= lastSlot) && (rdSlot <= lastSlot));

  // R8: a collision leaves the read position in place
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (mrs)
    (loadEn && readEn) |=> ($stable(rdSlot) && $stable(rdBit)));

endmodule

// File: rtl/ofs_chain_store.sv
module ofs_chain_store
  import ofs_chain_pkg::*;
#(
  parameter int               NUM_CH     = 4,
  parameter int               OFS_W      = 16,
  parameter logic [OFS_W-1:0] AE_DEFAULT = '0,
  parameter logic [OFS_W-1:0] AF_DEFAULT = '0
) (
  input  logic                       clk,
  input  logic                       mrs,
  input  logic                       serialIn,
  input  ofsStrobe_t                 strb,
  input  logic [$clog2(NUM_CH)-1:0]  wrCh,
  input  logic [$clog2(NUM_CH)-1:0]  rdCh,
  input  logic [$clog2(OFS_W)-1:0]   wrBit,
  input  logic [$clog2(OFS_W)-1:0]   rdBit,
  input  logic                       quadMode,
  output logic                       serialOut,
  output logic [NUM_CH*OFS_W-1:0]    aeFlat,
  output logic [NUM_CH*OFS_W-1:0]    afFlat
);

  localparam int TOTAL = NUM_CH * OFS_W;
  localparam int HALF  = (NUM_CH / 2) * OFS_W;

  logic [OFS_W-1:0] aeReg [NUM_CH];
  logic [OFS_W-1:0] afReg [NUM_CH];
  logic             rdVal;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (mrs) begin
        aeReg[c] <= AE_DEFAULT;
        afReg[c] <= AF_DEFAULT;
      end else if (strb.wr && (int'(wrCh) == c)) begin
        if (strb.wrAf) afReg[c][wrBit] <= serialIn;
        else           aeReg[c][wrBit] <= serialIn;
      end
    end
    assign aeFlat[c*OFS_W +: OFS_W] = aeReg[c];
    assign afFlat[c*OFS_W +: OFS_W] = afReg[c];
  end

  assign rdVal = strb.rdAf ? afReg[rdCh][rdBit] : aeReg[rdCh][rdBit];

  always_ff @(posedge clk) begin
    if (mrs)          serialOut <= 1'b0;
    else if (strb.rd) serialOut <= rdVal;
  end

  // R5: storage holds whenever no load strobe arrives
  p_store_hold_r5: assert property (@(posedge clk) disable iff (mrs)
    !strb.wr |=> ($stable(aeFlat) && $stable(afFlat)));

  // R7: one load strobe changes at most one stored bit
  p_one_bit_r7: assert property (@(posedge clk) disable iff (mrs)
    strb.wr |=> ($countones({aeFlat, afFlat} ^ $past({aeFlat, afFlat})) <= 1));

  // R10: serial output holds without a read
  p_sout_hold_r10: assert property (@(posedge clk) disable iff (mrs)
    !strb.rd |=> $stable(serialOut));

  // R4: upper channels are frozen in the half configuration
  p_upper_frozen_r4: assert property (@(posedge clk) disable iff (mrs)
    !quadMode |=> ($stable(aeFlat[TOTAL-1:HALF]) && $stable(afFlat[TOTAL-1:HALF])));

endmodule

// File: rtl/ofs_chain.sv
module ofs_chain
  import ofs_chain_pkg::*;
#(
  parameter int               NUM_CH     = 4,
  parameter int               OFS_W      = 16,
  parameter logic [OFS_W-1:0] AE_DEFAULT = 16'h007F,
  parameter logic [OFS_W-1:0] AF_DEFAULT = 16'h00FF
) (
  input  logic                    clk,
  input  logic                    mrs,
  input  logic                    quadSel,
  input  logic                    serialIn,
  input  logic                    loadEn,
  input  logic                    readEn,
  output logic                    serialOut,
  output logic [NUM_CH*OFS_W-1:0] aeOffsets,
  output logic [NUM_CH*OFS_W-1:0] afOffsets
);

  localparam int CHW = $clog2(NUM_CH);
  localparam int BW  = $clog2(OFS_W);

  ofsStrobe_t     strb;
  logic [CHW-1:0] wrCh, rdCh;
  logic [BW-1:0]  wrBit, rdBit;
  logic           quadMode;

  ofs_chain_ctrl #(.NUM_CH(NUM_CH), .OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .mrs(mrs), .quadSel(quadSel), .loadEn(loadEn), .readEn(readEn),
    .strb(strb), .wrCh(wrCh), .rdCh(rdCh), .wrBit(wrBit), .rdBit(rdBit),
    .quadMode(quadMode)
  );

  ofs_chain_store #(.NUM_CH(NUM_CH), .OFS_W(OFS_W),
                    .AE_DEFAULT(AE_DEFAULT), .AF_DEFAULT(AF_DEFAULT)) u_store (
    .clk(clk), .mrs(mrs), .serialIn(serialIn), .strb(strb),
    .wrCh(wrCh), .rdCh(rdCh), .wrBit(wrBit), .rdBit(rdBit), .quadMode(quadMode),
    .serialOut(serialOut), .aeFlat(aeOffsets), .afFlat(afOffsets)
  );

endmodule

// File: tb/ofs_chain_bench.sv
`timescale 1ns/1ps
module ofs_chain_bench;

  localparam int NCH = 4;
  localparam int W   = 16;
  localparam logic [W-1:0] DEF_AE = 16'h007F;
  localparam logic [W-1:0] DEF_AF = 16'h00FF;

  logic clk = 1'b0;
  logic mrs = 1'b1, quadSel = 1'b1, serialIn = 1'b0, loadEn = 1'b0, readEn = 1'b0;
  logic serialOut;
  logic [NCH*W-1:0] aeOffsets, afOffsets;

  int checks = 0, errors = 0, cycles = 0;

  // model
  logic [W-1:0] expAe [NCH];
  logic [W-1:0] expAf [NCH];
  bit mQuad;
  int mWr, mRd;

  always #2 clk = ~clk;

  ofs_chain u_ofs_chain (
    .clk(clk), .mrs(mrs), .quadSel(quadSel), .serialIn(serialIn),
    .loadEn(loadEn), .readEn(readEn), .serialOut(serialOut),
    .aeOffsets(aeOffsets), .afOffsets(afOffsets)
  );

  function automatic int chainLen();
    return (mQuad ? 2 * NCH : NCH) * W;
  endfunction

  function automatic bit expBit(int p);
    int slot = p / W;
    int b = p % W;
    int ch = (mQuad ? NCH : NCH / 2) - 1 - slot / 2;
    return (slot % 2) ? expAf[ch][b] : expAe[ch][b];
  endfunction

  task automatic modelWrite(bit v);
    int slot = mWr / W;
    int b = mWr % W;
    int ch = (mQuad ? NCH : NCH / 2) - 1 - slot / 2;
    if (slot % 2) expAf[ch][b] = v; else expAe[ch][b] = v;
    mWr = (mWr + 1) % chainLen();
  endtask

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkPar(string req);
    for (int c = 0; c < NCH; c++) begin
      check(aeOffsets[c*W +: W] === expAe[c], req, 64'(aeOffsets[c*W +: W]), 64'(expAe[c]));
      check(afOffsets[c*W +: W] === expAf[c], req, 64'(afOffsets[c*W +: W]), 64'(expAf[c]));
    end
  endtask

  task automatic doReset(bit q);
    @(negedge clk);
    mrs = 1'b1; quadSel = q; loadEn = 1'b0; readEn = 1'b0;
    @(negedge clk); @(negedge clk);
    mrs = 1'b0;
    mQuad = q; mWr = 0; mRd = 0;
    for (int c = 0; c < NCH; c++) begin expAe[c] = DEF_AE; expAf[c] = DEF_AF; end
  endtask

  task automatic pushBit(bit v);
    loadEn = 1'b1; serialIn = v;
    @(negedge clk);
    loadEn = 1'b0;
    modelWrite(v);
  endtask

  task automatic pushWord(logic [W-1:0] w);
    for (int b = 0; b < W; b++) pushBit(w[b]);
  endtask

  task automatic readBit(string req);
    bit e;
    e = expBit(mRd);
    readEn = 1'b1;
    @(negedge clk);
    readEn = 1'b0;
    check(serialOut === e, req, 64'(serialOut), 64'(e));
    mRd = (mRd + 1) % chainLen();
  endtask

  task automatic t_reset();
    doReset(1'b1);
    checkPar("R1 defaults");
    check(serialOut === 1'b0, "R1 serialOut", 64'(serialOut), 64'd0);
  endtask

  task automatic t_quad_load();
    logic [W-1:0] w0;
    for (int s = 0; s < 2 * NCH; s++) pushWord(W'(16'h1357 * (s + 1)) ^ 16'h8001);
    checkPar("R2 full chain order");
    w0 = W'(16'h1357) ^ 16'h8001;
    check(aeOffsets[(NCH-1)*W +: W] === w0, "R3 first register lsb first",
          64'(aeOffsets[(NCH-1)*W +: W]), 64'(w0));
  endtask

  task automatic t_readback();
    logic [NCH*W-1:0] ae0, af0;
    ae0 = aeOffsets; af0 = afOffsets;
    for (int i = 0; i < chainLen(); i++) readBit("R5 read stream");
    check(aeOffsets === ae0 && afOffsets === af0, "R5 contents intact",
          64'(aeOffsets), 64'(ae0));
    for (int i = 0; i < W; i++) readBit("R6 read wrap");
  endtask

  task automatic t_priority();
    logic so;
    bit e;
    readBit("R8 setup");
    so = serialOut;
    e = 1'b1 ^ expBit(mWr);
    loadEn = 1'b1; readEn = 1'b1; serialIn = e;
    @(negedge clk);
    loadEn = 1'b0; readEn = 1'b0;
    modelWrite(e);
    check(serialOut === so, "R8 serialOut held", 64'(serialOut), 64'(so));
    checkPar("R8 load taken");
    readBit("R8 read position kept");
  endtask

  task automatic t_hold();
    logic so;
    so = serialOut;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(serialOut === so, "R10 hold", 64'(serialOut), 64'(so));
    end
  endtask

  task automatic t_partial();
    doReset(1'b1);
    for (int i = 0; i < 20; i++) pushBit(1'b1);
    checkPar("R7 partial load");
    check(afOffsets[(NCH-1)*W +: W] === (DEF_AF | 16'h000F), "R7 partial register",
          64'(afOffsets[(NCH-1)*W +: W]), 64'(DEF_AF | 16'h000F));
    for (int i = 20; i < chainLen(); i++) pushBit(1'(i % 3 == 0));
    checkPar("R7 resumed load");
    check(mWr == 0, "R6 load wrap", 64'(mWr), 64'd0);
  endtask

  task automatic t_dual();
    doReset(1'b0);
    for (int s = 0; s < NCH; s++) pushWord(W'(16'hA5C3 + 16'h0F11 * s));
    checkPar("R4 half chain");
    check(aeOffsets[NCH*W-1:(NCH/2)*W] === {(NCH/2){DEF_AE}}, "R4 upper defaults",
          64'(aeOffsets[NCH*W-1:(NCH/2)*W]), 64'({(NCH/2){DEF_AE}}));
    for (int i = 0; i < chainLen() + W; i++) readBit("R4 half read stream");
  endtask

  task automatic t_cfg_lock();
    quadSel = 1'b1;
    for (int s = 0; s < NCH + 1; s++) pushWord(W'(16'h3C5A ^ (16'h0101 * s)));
    checkPar("R9 config locked");
    for (int i = 0; i < W; i++) readBit("R9 half length kept");
  endtask

  initial begin
    t_reset();
    t_quad_load();
    t_readback();
    t_priority();
    t_hold();
    t_partial();
    t_dual();
    t_cfg_lock();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule